// File: doc/BRIEF.md
# Bus address claim arbiter

This block resolves which agent on a shared parallel bus takes ownership of a transaction. An initiator presents an address for one clock (the address phase). Every positive target compares that address against its own base window and, if it matches, responds with a claim after a fixed number of clocks that is set per target. If no positive target claims within the three-clock response window, a single subtractive agent, a bridge, takes the transaction on the following clock and reissues the address as a new request on its downstream side.

Base addresses and enable bits come in as inputs, as if they were held in registers elsewhere. Window sizes and response speeds are build-time parameters. The outputs report when the claim happens, whether it was positive or subtractive, which target won, how many clocks the decode took, and whether more than one target matched. Once a claim has been made, the bus must stay idle for one clock before another address phase is accepted.

Top module: `bus_claim_arbiter`

## Requirements
- R1: A target matches when its enable bit is set and the address bits at and above its window size (log2 bytes) equal the same bits of its base. Base bits below the window size are ignored.
- R2: A positive claim comes `claim_o` high exactly L clocks after the address phase, where L is the winning target's latency parameter (1, 2 or 3). `latency_o` shows L and `claim_id_o` shows the target index.
- R3: If no enabled target matches, `claim_o` and `claim_sub_o` go high together on the 4th clock after the address phase, with `latency_o` = 4 and `claim_id_o` = 0.
- R4: A target whose enable bit is clear never claims, even when its window covers the address.
- R5: If two or more targets match, the lowest-indexed one is reported and the claim comes at its latency. `multi_err_o` is high in the claim cycle.
- R6: After a subtractive claim, `fwd_valid_o` is high for one clock, on the clock that follows the claim. In that clock `fwd_addr_o` carries the captured address. `fwd_valid_o` never rises after a positive claim.
- R7: `claim_o` is a single-clock pulse, and each accepted address phase produces exactly one.
- R8: `ready_o` drops on the clock after an accepted address phase. It stays low through the claim clock and one idle clock after it, then rises again. An address phase that arrives while `ready_o` is low is ignored.
- R9: After reset, `ready_o` is 1 and `claim_o`, `fwd_valid_o` and `multi_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_valid_i | input | 1 | Address phase strobe |
| addr_i | input | ADDR_W | Address in the address phase |
| bar_base_i | input | N_TGT*ADDR_W | Base address of each target, target 0 in the low bits |
| bar_en_i | input | N_TGT | Enable of each target's window |
| ready_o | output | 1 | An address phase would be accepted |
| claim_o | output | 1 | Transaction claimed this clock |
| claim_sub_o | output | 1 | The claim is subtractive |
| claim_id_o | output | $clog2(N_TGT) | Index of the claiming positive target |
| latency_o | output | 3 | Clocks from the address phase to the claim |
| multi_err_o | output | 1 | More than one target matched |
| fwd_valid_o | output | 1 | Bridge reissues the request downstream |
| fwd_addr_o | output | ADDR_W | Address of the reissued request |

## Verification
A positive claim and an overlap error can fall in the same clock. This is provoked with two enabled windows that cover one address, where the lower-indexed target is the fast one. The bench requires the claim, the lowest index, latency 1 and the error flag all in that single clock. A new address phase can also coincide with a decode that is still in progress: the bench strobes a fast-target address while a slow decode is pending, then requires that only the slow claim appears and that no stray claim follows once `ready_o` returns.

// File: rtl/bca_pkg.sv
package bca_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GAP  = 2'd2
  } bca_state_e;

  localparam int unsigned LAT_W   = 3;
  localparam logic [2:0]  SUB_LAT = 3'd4;
endpackage

// File: rtl/bar_decoder.sv
module bar_decoder #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SZ_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              en_i,
  output logic              hit_o
);
  // naturally aligned power-of-two window: compare bits above the size only
  assign hit_o = en_i && ((addr_i >> SZ_LOG2) == (base_i >> SZ_LOG2));
endmodule

// File: rtl/claim_select.sv
module claim_select #(
  parameter int unsigned         N_TGT   = 4,
  parameter logic [2*N_TGT-1:0]  TGT_LAT = '0,
  localparam int unsigned        ID_W    = $clog2(N_TGT)
) (
  input  logic [N_TGT-1:0] hit_i,
  output logic             any_o,
  output logic             multi_o,
  output logic [ID_W-1:0]  id_o,
  output logic [2:0]       lat_o
);
  int unsigned n_hit;

  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    lat_o = '0;
    n_hit = 0;
    // descend so the lowest index wins
    for (int i = N_TGT - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        id_o  = ID_W'(i);
        lat_o = {1'b0, TGT_LAT[2*i +: 2]};
        n_hit = n_hit + 1;
      end
    end
    multi_o = (n_hit > 1);
  end
endmodule

// File: rtl/bus_claim_arbiter.sv
module bus_claim_arbiter
  import bca_pkg::*;
#(
  parameter int unsigned        ADDR_W  = 32,
  parameter int unsigned        N_TGT   = 4,
  parameter logic [2*N_TGT-1:0] TGT_LAT = 8'b01_11_10_01,
  parameter logic [8*N_TGT-1:0] TGT_SZ  = 32'h0C_10_08_14,
  localparam int unsigned       ID_W    = $clog2(N_TGT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    addr_valid_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [N_TGT*ADDR_W-1:0] bar_base_i,
  input  logic [N_TGT-1:0]        bar_en_i,
  output logic                    ready_o,
  output logic                    claim_o,
  output logic                    claim_sub_o,
  output logic [ID_W-1:0]         claim_id_o,
  output logic [2:0]              latency_o,
  output logic                    multi_err_o,
  output logic                    fwd_valid_o,
  output logic [ADDR_W-1:0]       fwd_addr_o
);
  logic [N_TGT-1:0] hit;
  logic             sel_any, sel_multi;
  logic [ID_W-1:0]  sel_id;
  logic [2:0]       sel_lat;

  for (genvar g = 0; g < N_TGT; g++) begin : g_dec
    bar_decoder #(
      .ADDR_W (ADDR_W),
      .SZ_LOG2(int'(TGT_SZ[8*g +: 8]))
    ) u_dec (
      .addr_i(addr_i),
      .base_i(bar_base_i[ADDR_W*g +: ADDR_W]),
      .en_i  (bar_en_i[g]),
      .hit_o (hit[g])
    );
  end

  claim_select #(.N_TGT(N_TGT), .TGT_LAT(TGT_LAT)) u_sel (
    .hit_i  (hit),
    .any_o  (sel_any),
    .multi_o(sel_multi),
    .id_o   (sel_id),
    .lat_o  (sel_lat)
  );

  bca_state_e        state_q;
  logic [2:0]        cnt_q;
  logic              any_q, multi_q;
  logic [ID_W-1:0]   id_q;
  logic [2:0]        lat_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept, claim_now;

  assign accept    = (state_q == ST_IDLE) && addr_valid_i;
  assign claim_now = (state_q == ST_WAIT) &&
                     (any_q ? (cnt_q == lat_q) : (cnt_q == SUB_LAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      any_q   <= 1'b0;
      multi_q <= 1'b0;
      id_q    <= '0;
      lat_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_WAIT;
          cnt_q   <= 3'd1;
          any_q   <= sel_any;
          multi_q <= sel_multi;
          id_q    <= sel_id;
          lat_q   <= sel_lat;
          addr_q  <= addr_i;
        end
        ST_WAIT: begin
          cnt_q <= cnt_q + 3'd1;
          if (claim_now) state_q <= ST_GAP;
        end
        ST_GAP:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign claim_o     = claim_now;
  assign claim_sub_o = claim_now && !any_q;
  assign claim_id_o  = (claim_now && any_q) ? id_q : '0;
  assign latency_o   = claim_now ? cnt_q : '0;
  assign multi_err_o = claim_now && multi_q;
  assign fwd_valid_o = (state_q == ST_GAP) && !any_q;
  assign fwd_addr_o  = addr_q;

  assert_claim_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |=> !claim_o);
  assert_sub_lat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_sub_o |-> (claim_o && latency_o == SUB_LAT && claim_id_o == '0));
  assert_pos_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_o && !claim_sub_o) |-> (latency_o >= 3'd1 && latency_o <= 3'd3));
  assert_multi_pos_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_err_o |-> (claim_o && !claim_sub_o));
  assert_fwd_after_sub_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> $past(claim_sub_o));
  assert_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |=> !ready_o);
  assert_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && addr_valid_i) |=> !ready_o);
endmodule

// File: tb/tb_bus_claim_arbiter.sv
module tb_bus_claim_arbiter;
  localparam int AW = 32;
  localparam int N  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_valid = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N*AW-1:0] bases;
  logic [N-1:0]  ens;
  logic          ready, claim, claim_sub, multi_err, fwd_valid;
  logic [1:0]    claim_id;
  logic [2:0]    latency;
  logic [AW-1:0] fwd_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bus_claim_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_valid_i(addr_valid), .addr_i(addr),
    .bar_base_i(bases), .bar_en_i(ens), .ready_o(ready), .claim_o(claim),
    .claim_sub_o(claim_sub), .claim_id_o(claim_id), .latency_o(latency),
    .multi_err_o(multi_err), .fwd_valid_o(fwd_valid), .fwd_addr_o(fwd_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one transaction; cycle k is k clocks after the address phase
  task automatic run_txn(input logic [AW-1:0] a, input bit exp_sub,
                         input logic [1:0] exp_id, input int exp_lat,
                         input bit exp_err, input string req);
    int n_claim = 0;
    while (!ready) @(negedge clk);
    addr_valid = 1'b1; addr = a;
    @(negedge clk);
    addr_valid = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      if (claim) n_claim++;
      if (k == exp_lat) begin
        chk(claim == 1'b1, req, "claim", claim, 1);
        chk(claim_sub == exp_sub, req, "claim_sub", claim_sub, exp_sub);
        chk(latency == 3'(exp_lat), req, "latency", latency, exp_lat);
        chk(claim_id == exp_id, req, "claim_id", claim_id, exp_id);
        chk(multi_err == exp_err, req, "multi_err", multi_err, exp_err);
      end
      if (k == exp_lat + 1) begin
        chk(fwd_valid == exp_sub, "R6", "fwd_valid", fwd_valid, exp_sub);
        if (exp_sub) chk(fwd_addr == a, "R6", "fwd_addr", fwd_addr, a);
        chk(ready == 1'b0, "R8", "ready in gap", ready, 0);
      end
      if (k == exp_lat + 2) begin
        chk(ready == 1'b1, "R8", "ready after gap", ready, 1);
        chk(fwd_valid == 1'b0, "R6", "fwd_valid one clock", fwd_valid, 0);
      end
      @(negedge clk);
    end
    chk(n_claim == 1, "R7", "claims per txn", n_claim, 1);
  endtask

  task automatic test_reset;
    chk(ready == 1'b1, "R9", "ready", ready, 1);
    chk(claim == 1'b0, "R9", "claim", claim, 0);
    chk(fwd_valid == 1'b0, "R9", "fwd_valid", fwd_valid, 0);
    chk(multi_err == 1'b0, "R9", "multi_err", multi_err, 0);
  endtask

  task automatic test_positive;
    run_txn(32'h1008_0000, 1'b0, 2'd0, 1, 1'b0, "R1");  // t0 only, fast
    run_txn(32'h2000_00FF, 1'b0, 2'd1, 2, 1'b0, "R2");  // t1 top byte, medium
    run_txn(32'h3000_ABCD, 1'b0, 2'd2, 3, 1'b0, "R2");  // t2 slow
  endtask

  task automatic test_subtractive;
    run_txn(32'h2000_0100, 1'b1, 2'd0, 4, 1'b0, "R3");  // just past t1 window
    run_txn(32'h7777_0004, 1'b1, 2'd0, 4, 1'b0, "R3");
  endtask

  task automatic test_overlap;
    run_txn(32'h1000_0ABC, 1'b0, 2'd0, 1, 1'b1, "R5");  // t0 and t3 both hit
  endtask

  task automatic test_disabled;
    ens = 4'b1011;                                      // t2 off
    run_txn(32'h3000_1234, 1'b1, 2'd0, 4, 1'b0, "R4");
    ens = 4'b1110;                                      // t0 off, t3 alone
    run_txn(32'h1000_0ABC, 1'b0, 2'd3, 1, 1'b0, "R4");
    ens = 4'b1111;
  endtask

  task automatic test_busy_ignore;
    int n_claim = 0;
    int at = 0;
    while (!ready) @(negedge clk);
    addr_valid = 1'b1; addr = 32'h3000_0010;            // slow t2
    @(negedge clk);
    addr = 32'h1008_0000;                               // fast t0 while busy
    for (int k = 1; k <= 10; k++) begin
      if (k == 2) addr_valid = 1'b0;
      if (claim) begin n_claim++; at = k; end
      @(negedge clk);
    end
    chk(n_claim == 1, "R8", "claims with busy strobe", n_claim, 1);
    chk(at == 3, "R8", "claim clock", at, 3);
  endtask

  initial begin
    bases = {32'h1000_0000, 32'h3000_0000, 32'h2000_0055, 32'h1000_0000};
    ens   = 4'b1111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_positive();
    test_subtractive();
    test_overlap();
    test_disabled();
    test_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule